// File: doc/BRIEF.md
# Paged Switch Register Access Bridge

This block sits between a host processor's memory-mapped register bus and the internal configuration space of an Ethernet switch, where every register is named by an 8-bit page and an 8-bit register number. The host first claims the bridge: it sets a request bit and polls until a grant bit reads 1. The grant is only issued while a second, internal master has no transaction of its own in flight.

With ownership held, the host loads up to 64 bits of write data as two 32-bit words. It then writes a single command word that packs the page, the register, a direction bit and a go bit. The bridge turns that command into a request/acknowledge transaction on the switch side. When the switch acknowledges, the bridge clears the go bit and, for a read, captures the returned 64 bits into two read-data words. The host polls the go bit to see completion and finally drops its request to give ownership back.

A transaction the switch never answers is ended by a cycle limit, which sets a sticky error flag. A self-clearing reset bit in the command word aborts whatever the bridge is doing.

Top module: `swreg_bridge`

## Requirements
- R1: After reset the switch request, grant, interrupt enable and all host registers are 0, so the command word reads 0, the read-data words read 0, and the control word shows only the switch-ready flag at bit 6.
- R2: Writing 1 to control bit 3 (offset 0x40) raises the grant (control bit 4 and output `hostOwns`) on the first clock edge at which `altBusy` is low. The grant is never issued while `altBusy` is high. Clearing bit 3 withdraws the grant one cycle later.
- R3: The command word at offset 0x2c holds the page in bits 31:24, the register in bits 23:16, the direction in bit 1 (1 = write) and go in bit 0. A go accepted at a clock edge raises `swReq` from that edge, with `swPage`, `swReg` and `swWrite` taken from the word and `swWdata` = {word at 0x30, word at 0x34}.
- R4: A go written while the grant is not held is ignored: `swReq` stays low and bit 0 reads 0. The page, register and direction fields are still stored.
- R5: While `swReq` is high, bit 0 reads 1 and the switch-side fields stay stable. The edge at which `swAck` is high ends the transaction: `swReq` falls and bit 0 reads 0.
- R6: A completed read stores `swRdata[63:32]` at offset 0x38 and `swRdata[31:0]` at offset 0x3c. A completed write leaves both words unchanged.
- R7: If the switch does not acknowledge, `swReq` stays high for exactly TIMEOUT_CYCLES cycles and then falls, bit 0 clears and sticky bit 3 of the command word is set. Writing 1 to bit 3 clears it.
- R8: Writing 1 to command bit 2 aborts any transaction, clears the error flag and both read-data words, and does not reload the fields of a transaction it aborts. Bit 2 always reads 0.
- R9: Control bit 1 is a read/write interrupt enable that drives `hostIntEn`. Control bit 6 mirrors `swInitDone`. Writes to control bits 4 and 6 have no effect.
- R10: Read data appears on `hostRdata` one cycle after `hostRe`. The write-data words read back what was written, and undefined offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWe | input | 1 | Single-cycle host write strobe |
| hostRe | input | 1 | Host read strobe |
| hostAddr | input | 7 | Host byte address |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Registered host read data |
| hostIntEn | output | 1 | Host interrupt enable bit |
| hostOwns | output | 1 | Host holds the grant; the internal master must wait |
| altBusy | input | 1 | Internal master has a transaction in flight |
| swInitDone | input | 1 | Switch initialisation finished |
| swReq | output | 1 | Switch transaction request |
| swWrite | output | 1 | Switch transaction direction, 1 = write |
| swPage | output | 8 | Switch register page |
| swReg | output | 8 | Switch register number |
| swWdata | output | 64 | Switch write data |
| swAck | input | 1 | Switch acknowledge, one cycle |
| swRdata | input | 64 | Switch read data, valid with swAck |

## Verification
The bench writes a go while `altBusy` holds the grant off. A bridge that skipped the ownership check would start a switch transaction there. It then runs a read followed by a write, to catch a design that latches read data on every completion. It times an unanswered transaction to the exact cycle, where an off-by-one limit would drop `swReq` one cycle early or late. It also aborts a transaction with the reset bit, where a bridge that reloaded fields or kept stale read data would show the wrong words on readback.

// File: rtl/swreg_pkg.sv
package swreg_pkg;
  localparam int HOST_AW = 7;
  localparam int HOST_DW = 32;
  localparam int SW_DW   = 2 * HOST_DW;

  localparam logic [HOST_AW-1:0] OFF_CMD = 7'h2c;
  localparam logic [HOST_AW-1:0] OFF_WDH = 7'h30;
  localparam logic [HOST_AW-1:0] OFF_WDL = 7'h34;
  localparam logic [HOST_AW-1:0] OFF_RDH = 7'h38;
  localparam logic [HOST_AW-1:0] OFF_RDL = 7'h3c;
  localparam logic [HOST_AW-1:0] OFF_CTL = 7'h40;

  typedef struct packed {
    logic ldWdHi;
    logic ldWdLo;
    logic ldCmd;
    logic ldCtl;
    logic txDone;
    logic setErr;
    logic clrErr;
    logic softRst;
  } strobe_t;
endpackage

// File: rtl/swreg_ctrl.sv
module swreg_ctrl
  import swreg_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [HOST_DW-1:0] hostWdata,
  input  logic               reqBit,
  input  logic               altBusy,
  input  logic               swAck,
  output strobe_t            stb,
  output logic               busy,
  output logic               grant
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT_CYCLES - 1);

  logic [TW-1:0] timer;
  logic isCmd, startTx, tmo;

  always_comb begin
    isCmd       = hostWe && (hostAddr == OFF_CMD);
    stb.softRst = isCmd && hostWdata[2];
    startTx     = isCmd && hostWdata[0] && !hostWdata[2] && grant && !busy;
    tmo         = busy && !swAck && (timer == TLAST);
    stb.txDone  = busy && swAck && !stb.softRst;
    stb.setErr  = tmo && !stb.softRst;
    stb.clrErr  = isCmd && hostWdata[3];
    stb.ldCmd   = isCmd && !busy;
    stb.ldWdHi  = hostWe && (hostAddr == OFF_WDH);
    stb.ldWdLo  = hostWe && (hostAddr == OFF_WDL);
    stb.ldCtl   = hostWe && (hostAddr == OFF_CTL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      timer <= '0;
    end else if (stb.softRst) begin
      busy  <= 1'b0;
      timer <= '0;
    end else if (busy) begin
      if (swAck || tmo) begin
        busy  <= 1'b0;
        timer <= '0;
      end else begin
        timer <= timer + 1'b1;
      end
    end else if (startTx) begin
      busy  <= 1'b1;
      timer <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          grant <= 1'b0;
    else if (!reqBit)   grant <= 1'b0;
    else if (!altBusy)  grant <= 1'b1;
  end

  AST_GO_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(grant)); // R4
  AST_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grant) |-> $past(!altBusy && reqBit)); // R2
  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !reqBit |=> !grant); // R2
  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (timer < TW'(TIMEOUT_CYCLES))); // R7
  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && swAck) |=> !busy); // R5
endmodule

// File: rtl/swreg_dp.sv
module swreg_dp
  import swreg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic               hostRe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [HOST_DW-1:0] hostWdata,
  input  logic               busy,
  input  logic               grant,
  input  logic               swInitDone,
  input  logic [SW_DW-1:0]   swRdata,
  output logic [HOST_DW-1:0] hostRdata,
  output logic               reqBit,
  output logic               intEn,
  output logic [7:0]         cmdPage,
  output logic [7:0]         cmdReg,
  output logic               cmdWrite,
  output logic [SW_DW-1:0]   swWdata
);
  logic [HOST_DW-1:0] wdHi, wdLo, rdHi, rdLo, rdMux;
  logic errFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdHi <= '0; wdLo <= '0; reqBit <= 1'b0; intEn <= 1'b0;
      cmdPage <= '0; cmdReg <= '0; cmdWrite <= 1'b0;
    end else begin
      if (stb.ldWdHi) wdHi <= hostWdata;
      if (stb.ldWdLo) wdLo <= hostWdata;
      if (stb.ldCtl) begin
        reqBit <= hostWdata[3];
        intEn  <= hostWdata[1];
      end
      if (stb.ldCmd) begin
        cmdPage  <= hostWdata[31:24];
        cmdReg   <= hostWdata[23:16];
        cmdWrite <= hostWdata[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdHi <= '0; rdLo <= '0; errFlag <= 1'b0;
    end else if (stb.softRst) begin
      rdHi <= '0; rdLo <= '0; errFlag <= 1'b0;
    end else begin
      if (stb.txDone && !cmdWrite) begin
        rdHi <= swRdata[SW_DW-1:HOST_DW];
        rdLo <= swRdata[HOST_DW-1:0];
      end
      if (stb.setErr)      errFlag <= 1'b1;
      else if (stb.clrErr) errFlag <= 1'b0;
    end
  end

  always_comb begin
    case (hostAddr)
      OFF_CMD: rdMux = {cmdPage, cmdReg, 12'd0, errFlag, 1'b0, cmdWrite, busy};
      OFF_WDH: rdMux = wdHi;
      OFF_WDL: rdMux = wdLo;
      OFF_RDH: rdMux = rdHi;
      OFF_RDL: rdMux = rdLo;
      OFF_CTL: rdMux = {25'd0, swInitDone, 1'b0, grant, reqBit, 1'b0, intEn, 1'b0};
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       hostRdata <= '0;
    else if (hostRe) hostRdata <= rdMux;
  end

  assign swWdata = {wdHi, wdLo};

  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.txDone && !stb.softRst && !stb.setErr) |=> $stable({cmdPage, cmdReg, cmdWrite})); // R5
  AST_WRITE_KEEPS_RD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txDone && cmdWrite) |=> $stable({rdHi, rdLo})); // R6
  AST_SOFTRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> (rdHi == '0 && rdLo == '0 && !errFlag)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !stb.clrErr && !stb.softRst) |=> errFlag); // R7
endmodule

// File: rtl/swreg_bridge.sv
module swreg_bridge
  import swreg_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWe,
  input  logic        hostRe,
  input  logic [6:0]  hostAddr,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        hostIntEn,
  output logic        hostOwns,
  input  logic        altBusy,
  input  logic        swInitDone,
  output logic        swReq,
  output logic        swWrite,
  output logic [7:0]  swPage,
  output logic [7:0]  swReg,
  output logic [63:0] swWdata,
  input  logic        swAck,
  input  logic [63:0] swRdata
);
  strobe_t stb;
  logic busy, grant, reqBit;

  swreg_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .reqBit(reqBit), .altBusy(altBusy),
    .swAck(swAck), .stb(stb), .busy(busy), .grant(grant)
  );

  swreg_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostRe(hostRe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .busy(busy), .grant(grant), .swInitDone(swInitDone),
    .swRdata(swRdata), .hostRdata(hostRdata), .reqBit(reqBit), .intEn(hostIntEn),
    .cmdPage(swPage), .cmdReg(swReg), .cmdWrite(swWrite), .swWdata(swWdata)
  );

  assign swReq    = busy;
  assign hostOwns = grant;
endmodule

// File: tb/test_swreg_bridge.sv
`timescale 1ns/1ps
module test_swreg_bridge;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWe = 1'b0, hostRe = 1'b0;
  logic [6:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic hostIntEn, hostOwns;
  logic altBusy = 1'b1, swInitDone = 1'b1;
  logic swReq, swWrite;
  logic [7:0] swPage, swReg;
  logic [63:0] swWdata;
  logic swAck = 1'b0;
  logic [63:0] swRdata = '0;

  int nChecks = 0, nBad = 0;
  bit ackOn = 1'b0;
  int ackCnt = 0;
  localparam int ACK_DELAY = 3;

  logic [31:0] expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  swreg_bridge #(.TIMEOUT_CYCLES(TMO)) i_swreg_bridge (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostRe(hostRe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostIntEn(hostIntEn),
    .hostOwns(hostOwns), .altBusy(altBusy), .swInitDone(swInitDone), .swReq(swReq),
    .swWrite(swWrite), .swPage(swPage), .swReg(swReg), .swWdata(swWdata),
    .swAck(swAck), .swRdata(swRdata)
  );

  // switch responder
  always @(negedge clk) begin
    if (swAck) begin
      swAck = 1'b0;
      ackCnt = 0;
    end else if (swReq && ackOn) begin
      ackCnt++;
      if (ackCnt == ACK_DELAY) swAck = 1'b1;
    end else begin
      ackCnt = 0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after each hostRe
  always @(posedge clk) begin
    if (hostRe) begin
      #1;
      if (expQ.size() == 0) begin
        nChecks++; nBad++;
        $display("FAIL monitor actual=%h expected=none", hostRdata);
      end else begin
        chk(tagQ.pop_front(), {32'd0, hostRdata}, {32'd0, expQ.pop_front()});
      end
    end
  end

  task automatic hostWrite(input logic [6:0] a, input logic [31:0] d);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(posedge clk); @(negedge clk);
    hostWe = 1'b0; hostWdata = '0;
  endtask

  task automatic hostRead(input logic [6:0] a, input logic [31:0] exp, input string tag);
    hostRe = 1'b1; hostAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(posedge clk); @(negedge clk);
    hostRe = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 200 && swReq; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nChecks++; nBad++;
    $display("FAIL watchdog actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 swReq", swReq, 0);
    chk("R1 hostOwns", hostOwns, 0);
    chk("R1 hostIntEn", hostIntEn, 0);
    hostRead(7'h2c, 32'h0, "R1 cmd");
    hostRead(7'h3c, 32'h0, "R1 rdLo");
    hostRead(7'h40, 32'h40, "R1 ctrl");

    // R2 request held off by the internal master
    hostWrite(7'h40, 32'h8);
    repeat (3) @(negedge clk);
    chk("R2 no grant while altBusy", hostOwns, 0);
    hostRead(7'h40, 32'h48, "R2 ctrl no grant");

    // R4 go without grant
    hostWrite(7'h2c, 32'h7701_0001);
    chk("R4 swReq stays low", swReq, 0);
    hostRead(7'h2c, 32'h7701_0000, "R4 cmd fields stored");

    altBusy = 1'b0;
    @(negedge clk);
    chk("R2 grant issued", hostOwns, 1);
    hostRead(7'h40, 32'h58, "R2 ctrl granted");

    // R3 write transaction
    hostWrite(7'h30, 32'hDEAD_BEEF);
    hostWrite(7'h34, 32'h0123_4567);
    hostRead(7'h30, 32'hDEAD_BEEF, "R10 wdHi readback");
    ackOn = 1'b0;
    hostWrite(7'h2c, 32'h1234_0003);
    chk("R3 swReq", swReq, 1);
    chk("R3 swPage", swPage, 8'h12);
    chk("R3 swReg", swReg, 8'h34);
    chk("R3 swWrite", swWrite, 1);
    chk("R3 swWdata", swWdata, 64'hDEAD_BEEF_0123_4567);
    hostRead(7'h2c, 32'h1234_0003, "R5 busy reads 1");
    ackOn = 1'b1;
    waitIdle();
    chk("R5 swReq dropped", swReq, 0);
    hostRead(7'h2c, 32'h1234_0002, "R5 go cleared");
    hostRead(7'h38, 32'h0, "R6 write leaves rdHi");

    // R6 read transaction
    swRdata = 64'h0011_2233_4455_6677;
    hostWrite(7'h2c, 32'h0506_0001);
    chk("R3 read dir", swWrite, 0);
    waitIdle();
    hostRead(7'h38, 32'h0011_2233, "R6 rdHi");
    hostRead(7'h3c, 32'h4455_6677, "R6 rdLo");

    swRdata = 64'hFFFF_EEEE_DDDD_CCCC;
    hostWrite(7'h2c, 32'h0506_0003);
    waitIdle();
    hostRead(7'h38, 32'h0011_2233, "R6 rdHi kept after write");
    hostRead(7'h3c, 32'h4455_6677, "R6 rdLo kept after write");

    // R7 timeout
    ackOn = 1'b0;
    hostWrite(7'h2c, 32'h0909_0001);
    repeat (TMO - 1) @(negedge clk);
    chk("R7 swReq held to limit", swReq, 1);
    @(negedge clk);
    chk("R7 swReq dropped at limit", swReq, 0);
    hostRead(7'h2c, 32'h0909_0008, "R7 error set");
    hostWrite(7'h2c, 32'h0909_0008);
    hostRead(7'h2c, 32'h0909_0000, "R7 error cleared");

    // R8 soft reset aborts
    hostWrite(7'h2c, 32'h0A0B_0001);
    chk("R8 started", swReq, 1);
    hostWrite(7'h2c, 32'h0000_0004);
    chk("R8 aborted", swReq, 0);
    hostRead(7'h2c, 32'h0A0B_0000, "R8 cmd after reset");
    hostRead(7'h38, 32'h0, "R8 rdHi cleared");
    hostRead(7'h3c, 32'h0, "R8 rdLo cleared");

    // R9 interrupt enable, read-only bits
    swInitDone = 1'b0;
    hostWrite(7'h40, 32'h5A);
    chk("R9 hostIntEn", hostIntEn, 1);
    hostRead(7'h40, 32'h1A, "R9 ctrl readback");

    // R10 undefined offsets
    hostRead(7'h00, 32'h0, "R10 offset 0x00");
    hostRead(7'h44, 32'h0, "R10 offset 0x44");

    // R2 release
    hostWrite(7'h40, 32'h0);
    chk("R2 grant one more cycle", hostOwns, 1);
    @(negedge clk);
    chk("R2 grant withdrawn", hostOwns, 0);
    hostRead(7'h40, 32'h0, "R2 ctrl released");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule